// File: doc/BRIEF.md
# Micro-Step Accumulator CPU

This block is a small accumulator machine. Its control unit runs each instruction as a short list of register-transfer micro-steps. The datapath holds a program counter, a memory address register, a memory buffer register, an instruction register and a 16-bit accumulator. The block connects to one single-port word memory through an address bus, a read strobe, a write strobe and separate read and write data buses. When the read strobe is high, the memory must present the addressed word on the read bus in that same cycle, and the buffer register takes it at the closing clock edge.

Each instruction starts with a three-step fetch. Step 0 only copies the program counter into the address register. Step 1 reads memory and increments the program counter in the same clock. Step 2 moves the fetched word into the instruction register. An add or load in immediate form then needs one more step. In direct form it needs three more: load the address, read the operand, update the accumulator. A direct store needs two more steps, because it loads the address register and the buffer register together in one clock. No step writes a register that the same step reads for another transfer.

A step counter and a pulse that marks the last step of each instruction are brought out, so the cost of every instruction can be observed from outside the block.

Top module: `ustep_acc_cpu`

## Requirements
- R1: While synchronous active-high reset is applied, the program counter, the accumulator and the step counter are zero, `instr_done`, `halted` and `mem_wr` are low, and the first fetch after reset reads address 0.
- R2: In step 0 the block drives neither strobe. In step 1 `mem_rd` is high, `mem_addr` equals the program counter, and the program counter advances by one at the end of that same step.
- R3: Fetch takes steps 0, 1 and 2, so no instruction ends before step 3.
- R4: The instruction word is split as bits [15:12] opcode, bit [11] mode (0 immediate, 1 direct) and bits [10:0] operand. The opcodes are 0001 add, 0010 load, 0011 store and 1111 halt. The step in which an instruction ends follows from these fields.
- R5: An immediate add (0001, mode 0) adds the zero-extended operand to the accumulator modulo 2^16 and ends in step 3. From step 3 on, no immediate-mode instruction drives a memory strobe.
- R6: A direct add (0001, mode 1) reads the word at the operand address in step 4, with `mem_rd` high and `mem_addr` equal to the operand. It adds that word to the accumulator modulo 2^16 and ends in step 5.
- R7: A load (0010) follows the same timing as the add in each mode, but it replaces the accumulator with the zero-extended operand or with the memory word.
- R8: A direct store (0011, mode 1) raises `mem_wr` in step 4 with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator, and ends there. A store in mode 0 changes nothing in memory or the accumulator and ends in step 3.
- R9: An opcode that is not defined leaves the accumulator unchanged, ends in step 3, and the next fetch reads the following address.
- R10: Halt (1111) ends in step 3. From the next cycle until reset, `halted` stays high, no strobe is driven and the accumulator and program counter do not change.
- R11: The step counter is 0 in the first fetch step, grows by one each clock, and returns to 0 after the step in which the one-cycle `instr_done` pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory word address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is taken the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data from memory |
| acc_out | output | 16 | Accumulator value |
| step_no | output | 3 | Micro-step number within the current instruction |
| instr_done | output | 1 | High during the last step of an instruction |
| halted | output | 1 | High once a halt has completed |

## Verification
The assertions check the fetch grouping on every cycle. Step 0 drives no strobe, step 1 reads at the program counter and bumps it. They also check that the step counter advances or restarts, that immediate-mode execute steps leave memory alone, that halt freezes the state, and that store data equals the accumulator. Only the bench scenarios can show the rest: that each opcode and mode ends in its own step, and that accumulator results are right, including wrap past 2^16. They also show that direct operands and stored words travel through memory correctly, that undefined and mode-0 store words do nothing, and that reset after a halt restarts cleanly.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

  localparam int WORD_W_DEF = 16;
  localparam int OPC_W_DEF  = 4;

  localparam int OPC_ADD   = 1;
  localparam int OPC_LOAD  = 2;
  localparam int OPC_STORE = 3;
  localparam int OPC_HALT  = 15;

  typedef enum logic [2:0] {
    PH_F0, PH_F1, PH_F2, PH_X0, PH_X1, PH_X2, PH_STOP
  } phase_t;

  typedef enum logic [1:0] {MAR_HOLD, MAR_FROM_PC, MAR_FROM_IR} mar_sel_t;
  typedef enum logic [1:0] {MBR_HOLD, MBR_FROM_MEM, MBR_FROM_ACC} mbr_sel_t;
  typedef enum logic [2:0] {
    ACC_HOLD, ACC_ADD_IMM, ACC_ADD_MBR, ACC_LD_IMM, ACC_LD_MBR
  } acc_op_t;

  // one micro-step worth of control
  typedef struct packed {
    mar_sel_t mar_sel;
    mbr_sel_t mbr_sel;
    logic     pc_inc;
    logic     ir_load;
    acc_op_t  acc_op;
    logic     mem_rd;
    logic     mem_wr;
    logic     last;
    logic     stop;
  } uop_t;

endpackage

// File: rtl/ustep_alu.sv
module ustep_alu
  import ustep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ARG_W  = 11
) (
  input  acc_op_t             op,
  input  logic [DATA_W-1:0]   acc,
  input  logic [DATA_W-1:0]   mbr,
  input  logic [ARG_W-1:0]    arg,
  output logic [DATA_W-1:0]   acc_nx
);

  function automatic logic [DATA_W-1:0] widen(input logic [ARG_W-1:0] a);
    return DATA_W'(a);
  endfunction

  function automatic logic [DATA_W-1:0] sum_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  always_comb begin
    case (op)
      ACC_ADD_IMM: acc_nx = sum_wrap(acc, widen(arg));
      ACC_ADD_MBR: acc_nx = sum_wrap(acc, mbr);
      ACC_LD_IMM:  acc_nx = widen(arg);
      ACC_LD_MBR:  acc_nx = mbr;
      default:     acc_nx = acc;
    endcase
  end

endmodule

// File: rtl/ustep_regs.sv
module ustep_regs
  import ustep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  uop_t              uop,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] acc_nx,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] acc_q
);

  always_ff @(posedge clk) begin
    if (rst)             pc_q <= '0;
    else if (uop.pc_inc) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mar_q <= '0;
    else begin
      case (uop.mar_sel)
        MAR_FROM_PC: mar_q <= pc_q;
        MAR_FROM_IR: mar_q <= ir_q[ADDR_W-1:0];
        default:     mar_q <= mar_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mbr_q <= '0;
    else begin
      case (uop.mbr_sel)
        MBR_FROM_MEM: mbr_q <= mem_rdata;
        MBR_FROM_ACC: mbr_q <= acc_q;
        default:      mbr_q <= mbr_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ir_q <= '0;
    else if (uop.ir_load) ir_q <= mbr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                         acc_q <= '0;
    else if (uop.acc_op != ACC_HOLD) acc_q <= acc_nx;
  end

endmodule

// File: rtl/ustep_seq.sv
module ustep_seq
  import ustep_pkg::*;
#(
  parameter int OPC_W  = 4,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opc,
  input  logic              dir_mode,
  output uop_t              uop,
  output phase_t            phase,
  output logic [STEP_W-1:0] step_cnt
);

  phase_t phase_nx;
  logic   is_add, is_load, is_store, is_halt;

  assign is_add   = (opc == OPC_W'(OPC_ADD));
  assign is_load  = (opc == OPC_W'(OPC_LOAD));
  assign is_store = (opc == OPC_W'(OPC_STORE));
  assign is_halt  = (opc == OPC_W'(OPC_HALT));

  // micro-step decode
  always_comb begin
    uop = '0;
    case (phase)
      PH_F0: uop.mar_sel = MAR_FROM_PC;
      PH_F1: begin
        uop.mbr_sel = MBR_FROM_MEM;
        uop.mem_rd  = 1'b1;
        uop.pc_inc  = 1'b1;
      end
      PH_F2: uop.ir_load = 1'b1;
      PH_X0: begin
        if (is_add || is_load) begin
          if (dir_mode) uop.mar_sel = MAR_FROM_IR;
          else begin
            uop.acc_op = is_add ? ACC_ADD_IMM : ACC_LD_IMM;
            uop.last   = 1'b1;
          end
        end else if (is_store && dir_mode) begin
          uop.mar_sel = MAR_FROM_IR;
          uop.mbr_sel = MBR_FROM_ACC;
        end else begin
          uop.last = 1'b1;
          uop.stop = is_halt;
        end
      end
      PH_X1: begin
        if ((is_add || is_load) && dir_mode) begin
          uop.mbr_sel = MBR_FROM_MEM;
          uop.mem_rd  = 1'b1;
        end else if (is_store && dir_mode) begin
          uop.mem_wr = 1'b1;
          uop.last   = 1'b1;
        end else begin
          uop.last = 1'b1;
        end
      end
      PH_X2: begin
        if (is_add)       uop.acc_op = ACC_ADD_MBR;
        else if (is_load) uop.acc_op = ACC_LD_MBR;
        uop.last = 1'b1;
      end
      default: uop = '0;
    endcase
  end

  always_comb begin
    case (phase)
      PH_F0:   phase_nx = PH_F1;
      PH_F1:   phase_nx = PH_F2;
      PH_F2:   phase_nx = PH_X0;
      PH_X0:   phase_nx = uop.stop ? PH_STOP : (uop.last ? PH_F0 : PH_X1);
      PH_X1:   phase_nx = uop.last ? PH_F0 : PH_X2;
      PH_X2:   phase_nx = PH_F0;
      PH_STOP: phase_nx = PH_STOP;
      default: phase_nx = PH_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_F0;
    else     phase <= phase_nx;
  end

  always_ff @(posedge clk) begin
    if (rst)                    step_cnt <= '0;
    else if (phase != PH_STOP)  step_cnt <= uop.last ? '0 : step_cnt + 1'b1;
  end

endmodule

// File: rtl/ustep_acc_cpu.sv
module ustep_acc_cpu
  import ustep_pkg::*;
#(
  parameter int DATA_W = ustep_pkg::WORD_W_DEF,
  parameter int OPC_W  = ustep_pkg::OPC_W_DEF
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [DATA_W-OPC_W-2:0]     mem_addr,
  output logic                        mem_rd,
  output logic                        mem_wr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic [DATA_W-1:0]           acc_out,
  output logic [2:0]                  step_no,
  output logic                        instr_done,
  output logic                        halted
);

  localparam int ADDR_W = DATA_W - OPC_W - 1;
  localparam int STEP_W = 3;

  uop_t               uop;
  phase_t             phase;
  logic [ADDR_W-1:0]  pc_q, mar_q;
  logic [DATA_W-1:0]  mbr_q, ir_q, acc_q, acc_nx;
  logic [OPC_W-1:0]   ir_opc;
  logic               ir_mode;
  logic [ADDR_W-1:0]  ir_arg;
  logic [STEP_W-1:0]  step_cnt;

  assign ir_opc  = ir_q[DATA_W-1 -: OPC_W];
  assign ir_mode = ir_q[ADDR_W];
  assign ir_arg  = ir_q[ADDR_W-1:0];

  ustep_seq #(.OPC_W(OPC_W), .STEP_W(STEP_W)) seq_i (
    .clk(clk), .rst(rst), .opc(ir_opc), .dir_mode(ir_mode),
    .uop(uop), .phase(phase), .step_cnt(step_cnt)
  );

  ustep_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .uop(uop), .mem_rdata(mem_rdata), .acc_nx(acc_nx),
    .pc_q(pc_q), .mar_q(mar_q), .mbr_q(mbr_q), .ir_q(ir_q), .acc_q(acc_q)
  );

  ustep_alu #(.DATA_W(DATA_W), .ARG_W(ADDR_W)) alu_i (
    .op(uop.acc_op), .acc(acc_q), .mbr(mbr_q), .arg(ir_arg), .acc_nx(acc_nx)
  );

  assign mem_addr   = mar_q;
  assign mem_wdata  = mbr_q;
  assign mem_rd     = uop.mem_rd;
  assign mem_wr     = uop.mem_wr;
  assign acc_out    = acc_q;
  assign step_no    = step_cnt;
  assign instr_done = uop.last;
  assign halted     = (phase == PH_STOP);

endmodule

// File: rtl/ustep_acc_cpu_chk.sv
module ustep_acc_cpu_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        step_no,
  input logic              instr_done,
  input logic              halted,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              ir_mode
);

  AST_FETCH_ADDR_ALONE: assert property (@(posedge clk) disable iff (rst)
    (!halted && step_no == 3'd0) |-> (!mem_rd && !mem_wr)); // R2

  AST_FETCH_READ_AT_PC: assert property (@(posedge clk) disable iff (rst)
    (!halted && step_no == 3'd1) |-> (mem_rd && mem_addr == pc_q)); // R2

  AST_PC_BUMP_WITH_READ: assert property (@(posedge clk) disable iff (rst)
    (!halted && step_no == 3'd1) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R2

  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> (step_no >= 3'd3 && step_no <= 3'd5)); // R3

  AST_IMM_NO_MEMORY: assert property (@(posedge clk) disable iff (rst)
    (!halted && step_no >= 3'd3 && !ir_mode) |-> (!mem_rd && !mem_wr)); // R5

  AST_STORE_DATA_ACC: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == acc_q && step_no == 3'd4)); // R8

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(acc_q) && $stable(pc_q) && !mem_rd && !mem_wr)); // R10

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!halted && !instr_done) |=> (step_no == $past(step_no) + 3'd1)); // R11

  AST_STEP_RESTART: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> (step_no == 3'd0)); // R11

endmodule

bind ustep_acc_cpu ustep_acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .step_no(step_no), .instr_done(instr_done),
  .halted(halted), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .pc_q(pc_q), .acc_q(acc_q), .ir_mode(ir_mode)
);

// File: tb/ustep_acc_cpu_tb_top.sv
`timescale 1ns/1ps
module ustep_acc_cpu_tb_top;
  localparam int DW = 16;
  localparam int AW = 11;
  localparam int MEMN = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, instr_done, halted;
  logic [DW-1:0] mem_wdata, mem_rdata, acc_out;
  logic [2:0] step_no;
  logic [DW-1:0] mem [MEMN];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ustep_acc_cpu dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_out(acc_out),
    .step_no(step_no), .instr_done(instr_done), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input int op, input bit md, input int arg);
    return {4'(op), md, 11'(arg)};
  endfunction

  function automatic int end_step(input logic [3:0] op, input bit md);
    if ((op == 4'd1 || op == 4'd2) && md) return 5;
    if (op == 4'd3 && md) return 4;
    return 3;
  endfunction

  function automatic logic [DW-1:0] model_acc(input logic [3:0] op, input bit md,
      input logic [10:0] arg, input logic [DW-1:0] acc, input logic [DW-1:0] word);
    logic [DW-1:0] v;
    v = md ? word : {5'b0, arg};
    if (op == 4'd1) return acc + v;
    if (op == 4'd2) return v;
    return acc;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input bit md);
    if (op == 4'd1) return md ? "R6" : "R5";
    if (op == 4'd2) return "R7";
    if (op == 4'd3) return "R8";
    if (op == 4'd15) return "R10";
    return "R9";
  endfunction

  // bench-side instruction model
  bit mon_en = 1'b0;
  bit mhalt, pend;
  int mpc, mcnt;
  logic [DW-1:0] macc, cur_ir;
  string pend_tag;

  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (pend) begin
        chk(acc_out == macc, pend_tag, "accumulator after instruction", acc_out, macc);
        pend = 1'b0;
      end
      if (mhalt) begin
        chk(halted && !mem_rd && !mem_wr && acc_out == macc, "R10",
            "halted frozen state", {halted, mem_rd, mem_wr}, 3'b100);
      end else begin
        chk(step_no == 3'(mcnt), "R11", "step number", step_no, mcnt);
        if (mcnt == 0)
          chk(!mem_rd && !mem_wr, "R2", "no strobe in step 0", {mem_rd, mem_wr}, 0);
        if (mcnt == 1) begin
          chk(mem_rd && mem_addr == AW'(mpc), "R2", "fetch address", mem_addr, mpc);
          cur_ir = mem_rdata;
          mpc = (mpc + 1) % MEMN;
        end
        if (mcnt >= 3 && !cur_ir[11])
          chk(!mem_rd && !mem_wr, "R5", "immediate mode memory idle", {mem_rd, mem_wr}, 0);
        if (mcnt == 4 && cur_ir[11] && (cur_ir[15:12] == 4'd1 || cur_ir[15:12] == 4'd2))
          chk(mem_rd && mem_addr == cur_ir[10:0], tag_of(cur_ir[15:12], 1'b1),
              "operand read address", mem_addr, cur_ir[10:0]);
        if (mem_wr)
          chk(cur_ir[15:12] == 4'd3 && cur_ir[11] && mem_addr == cur_ir[10:0] &&
              mem_wdata == macc, "R8", "store address/data", mem_wdata, macc);
        if (mcnt < 3)
          chk(!instr_done, "R3", "no end during fetch", instr_done, 0);
        else
          chk(instr_done == (mcnt == end_step(cur_ir[15:12], cur_ir[11])), "R4",
              "end step from decoded fields", mcnt, end_step(cur_ir[15:12], cur_ir[11]));
        if (instr_done) begin
          macc = model_acc(cur_ir[15:12], cur_ir[11], cur_ir[10:0], macc, mem[cur_ir[10:0]]);
          pend_tag = tag_of(cur_ir[15:12], cur_ir[11]);
          pend = 1'b1;
          if (cur_ir[15:12] == 4'd15) mhalt = 1'b1;
          mcnt = 0;
        end else begin
          mcnt++;
        end
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < MEMN; i++) mem[i] <= '0;
  endtask

  task automatic start_run();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(step_no == 0 && acc_out == 0 && !instr_done && !halted && !mem_wr, "R1",
        "reset state", {acc_out, step_no, instr_done, halted}, 0);
    mpc = 0; mcnt = 0; macc = '0; mhalt = 1'b0; pend = 1'b0; cur_ir = '0;
    @(posedge clk);
    #1 rst = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic finish_run(input int limit);
    int n = 0;
    while (!mhalt && n < limit) begin
      @(negedge clk);
      n++;
    end
    if (!mhalt) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=%0h expected=%0h", 0, 1);
    end
    repeat (16) @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd51973);
    rst = 1'b1;

    // directed program: wrap, direct operands, store, no-ops, halt
    clear_mem();
    @(posedge clk);
    mem[0]   <= ins(2, 0, 5);
    mem[1]   <= ins(1, 0, 7);
    mem[2]   <= ins(1, 1, 100);
    mem[3]   <= ins(1, 0, 11'h7FF);
    mem[4]   <= ins(3, 1, 200);
    mem[5]   <= ins(2, 0, 0);
    mem[6]   <= ins(2, 1, 200);
    mem[7]   <= ins(5, 1, 100);
    mem[8]   <= ins(3, 0, 300);
    mem[9]   <= ins(1, 1, 200);
    mem[10]  <= ins(15, 0, 0);
    mem[100] <= 16'hFFF0;
    start_run();
    finish_run(400);
    chk(mem[200] == 16'h07FB, "R8", "stored word", mem[200], 16'h07FB);
    chk(mem[300] == 16'h0000, "R8", "mode-0 store writes nothing", mem[300], 0);
    chk(acc_out == 16'h0FF6, "R6", "final accumulator", acc_out, 16'h0FF6);

    // random programs
    for (int run = 0; run < 4; run++) begin
      clear_mem();
      @(posedge clk);
      for (int i = 0; i < 48; i++) begin
        int op;
        case ($urandom_range(0, 4))
          0: op = 1;
          1: op = 2;
          2: op = 3;
          3: op = 7;
          default: op = 0;
        endcase
        mem[i] <= ins(op, 1'($urandom_range(0, 1)), 512 + $urandom_range(0, 511));
      end
      for (int i = 512; i < 1024; i++) mem[i] <= 16'($urandom());
      mem[48] <= ins(15, 1, 0);
      start_run();
      finish_run(2000);
    end

    // halt as the very first instruction
    clear_mem();
    @(posedge clk);
    mem[0] <= ins(15, 0, 0);
    start_run();
    finish_run(50);
    chk(acc_out == 0, "R10", "accumulator after immediate halt", acc_out, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL R10 global watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule